// File: doc/BRIEF.md
# DMA Channel Programming Register File

This block is the processor-facing register set of a four-channel DMA controller. The processor reaches it through an 8-bit data port, a 4-bit register offset, a chip select and separate read and write strobes. Each cycle in which chip select and exactly one strobe are high counts as one access. For every channel the block holds a 16-bit start address, a 16-bit start count, and a working copy of each. It also holds a command byte, one mode byte per channel, software request bits, mask bits, terminal-count flags and a temporary byte. All of these values are driven out to the transfer engine. The engine writes the working address and count back, raises terminal-count flags, and loads the temporary byte.

The 16-bit registers are reached through the 8-bit port by a byte-select state machine with two states. BP_LOW selects the low byte and BP_HIGH selects the high byte. The transition "step" moves from one state to the other on every read or write of an address or count offset. The transition "clear" forces BP_LOW on a pointer-reset write or a master-clear write, and clear takes priority over step. Several offsets are pure commands: the write itself is the action and its data is either ignored or used as a small field.

Top module: `dma_regfile`

## Requirements
- R1: After reset, every mask bit is 1. The command byte, request bits, terminal-count flags, temporary byte, modes, addresses and counts are all 0, and the byte select is in BP_LOW.
- R2: A write to offset 2n (address) or 2n+1 (count) of channel n stores the data byte into both the start copy and the working copy. The low byte is written in BP_LOW and the high byte in BP_HIGH.
- R3: A read of offset 2n or 2n+1 returns the low byte (in BP_LOW) or the high byte (in BP_HIGH) of the working copy. Every read or write of offsets 0 to 7 takes the step transition.
- R4: A write to offset 0xC takes the clear transition and changes no other state.
- R5: A write to offset 8 loads the command byte. A write to offset 0xB stores the whole data byte as the mode of the channel named by data bits [1:0].
- R6: A write to offset 0xA sets the mask bit of the channel named by data bits [1:0] to data bit 2. A write to 0xE clears all four mask bits. A write to 0xF loads the mask bits from data bits [3:0].
- R7: A write to offset 9 sets the software request bit of the channel named by data bits [1:0] to data bit 2. Status bits [7:4] report the OR of the hardware request inputs and the software request bits.
- R8: An engine update with its terminal-count flag raised sets status bit [n] for the engine's channel n. A read of offset 8 returns the status byte and clears bits [3:0] after that cycle. A flag set in the same cycle as the read survives.
- R9: A write to offset 0xD clears the command, request, terminal-count flags and temporary byte, sets all mask bits, and takes the clear transition. It leaves addresses, counts and modes unchanged.
- R10: An engine update loads the working address and working count of its channel on the next clock and leaves both start copies unchanged. If a processor write to the same register lands in the same cycle, the processor write wins for that register.
- R11: A temporary-load pulse captures the engine's byte, and a read of offset 0xD returns that byte.
- R12: rdata is 0 when no read is in progress and when the read offset is 9, 0xA, 0xB, 0xC, 0xE or 0xF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| hw_req | input | 4 | Hardware request lines, one per channel |
| eng_we | input | 1 | Engine update strobe |
| eng_ch | input | 2 | Channel of the engine update |
| eng_addr | input | 16 | New working address |
| eng_cnt | input | 16 | New working count |
| eng_tc | input | 1 | Terminal count reached by this update |
| temp_load | input | 1 | Load strobe for the temporary byte |
| temp_data | input | 8 | Temporary byte from the engine |
| cmd_o | output | 8 | Command byte |
| mode_o | output | 32 | Mode bytes, channel n in bits [8n+7:8n] |
| mask_o | output | 4 | Mask bits |
| sw_req_o | output | 4 | Software request bits |
| base_addr_o | output | 64 | Start addresses, channel n in bits [16n+15:16n] |
| cur_addr_o | output | 64 | Working addresses, same layout |
| base_cnt_o | output | 64 | Start counts, same layout |
| cur_cnt_o | output | 64 | Working counts, same layout |

## Verification
Every write and every engine update shows on the outputs one clock after the strobe. The read data is combinational: it reflects the byte select and register state of the cycle in which the read is presented. Read side effects (the step transition, the clearing of the terminal-count flags) show on the following clock. The bench drives its inputs 2 ns after the rising edge and compares every output with a behavioural model at the falling edge, so each result is sampled after exactly the register stages the requirements describe. Directed reads sample rdata at the falling edge of the cycle that carries the read.

// File: rtl/dma_regfile_pkg.sv
package dma_regfile_pkg;
    localparam int NCH    = 4;
    localparam int CH_W   = $clog2(NCH);
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int OFS_W  = 4;

    typedef enum logic {
        BP_LOW,
        BP_HIGH
    } bp_state_t;

    typedef enum logic [3:0] {
        OP_ADDR,
        OP_CNT,
        OP_CMD,
        OP_REQ,
        OP_MASK1,
        OP_MODE,
        OP_BPCLR,
        OP_MCLR,
        OP_MASKCLR,
        OP_MASKALL
    } reg_op_t;

    typedef struct packed {
        logic            rd;
        logic            wr;
        reg_op_t         op;
        logic [CH_W-1:0] ch;
    } access_t;

    function automatic logic [WORD_W-1:0] put_byte(input logic [WORD_W-1:0] word,
                                                   input logic hi,
                                                   input logic [BYTE_W-1:0] b);
        logic [WORD_W-1:0] r;
        r = word;
        if (hi) r[WORD_W-1:BYTE_W] = b;
        else    r[BYTE_W-1:0]      = b;
        return r;
    endfunction
endpackage

// File: rtl/dma_bus_decode.sv
module dma_bus_decode
    import dma_regfile_pkg::*;
(
    input  logic             cs,
    input  logic             rd,
    input  logic             wr,
    input  logic [OFS_W-1:0] addr,
    output access_t          acc
);
    always_comb begin
        acc.rd = cs && rd && !wr;
        acc.wr = cs && wr && !rd;
        acc.ch = addr[CH_W:1];
        if (!addr[OFS_W-1]) begin
            acc.op = addr[0] ? OP_CNT : OP_ADDR;
        end else begin
            unique case (addr[2:0])
                3'd0: acc.op = OP_CMD;
                3'd1: acc.op = OP_REQ;
                3'd2: acc.op = OP_MASK1;
                3'd3: acc.op = OP_MODE;
                3'd4: acc.op = OP_BPCLR;
                3'd5: acc.op = OP_MCLR;
                3'd6: acc.op = OP_MASKCLR;
                3'd7: acc.op = OP_MASKALL;
            endcase
        end
    end
endmodule

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr
    import dma_regfile_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic clear,
    output logic hi_sel
);
    bp_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BP_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BP_LOW:  if (!clear && step)  state_d = BP_HIGH;
            BP_HIGH: if (clear || step)   state_d = BP_LOW;
        endcase
    end

    always_comb begin
        hi_sel = (state_q == BP_HIGH);
    end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_regfile_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_we,
    input  logic              cnt_we,
    input  logic              hi_sel,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              eng_we,
    input  logic [WORD_W-1:0] eng_addr,
    input  logic [WORD_W-1:0] eng_cnt,
    output logic [WORD_W-1:0] base_addr,
    output logic [WORD_W-1:0] cur_addr,
    output logic [WORD_W-1:0] base_cnt,
    output logic [WORD_W-1:0] cur_cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_addr <= '0;
            cur_addr  <= '0;
            base_cnt  <= '0;
            cur_cnt   <= '0;
        end else begin
            if (addr_we) begin
                base_addr <= put_byte(base_addr, hi_sel, wdata);
                cur_addr  <= put_byte(cur_addr, hi_sel, wdata);
            end else if (eng_we) begin
                cur_addr  <= eng_addr;
            end
            if (cnt_we) begin
                base_cnt <= put_byte(base_cnt, hi_sel, wdata);
                cur_cnt  <= put_byte(cur_cnt, hi_sel, wdata);
            end else if (eng_we) begin
                cur_cnt  <= eng_cnt;
            end
        end
    end
endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
    import dma_regfile_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cs,
    input  logic                    rd,
    input  logic                    wr,
    input  logic [OFS_W-1:0]        addr,
    input  logic [BYTE_W-1:0]       wdata,
    output logic [BYTE_W-1:0]       rdata,
    input  logic [NCH-1:0]          hw_req,
    input  logic                    eng_we,
    input  logic [CH_W-1:0]         eng_ch,
    input  logic [WORD_W-1:0]       eng_addr,
    input  logic [WORD_W-1:0]       eng_cnt,
    input  logic                    eng_tc,
    input  logic                    temp_load,
    input  logic [BYTE_W-1:0]       temp_data,
    output logic [BYTE_W-1:0]       cmd_o,
    output logic [NCH*BYTE_W-1:0]   mode_o,
    output logic [NCH-1:0]          mask_o,
    output logic [NCH-1:0]          sw_req_o,
    output logic [NCH*WORD_W-1:0]   base_addr_o,
    output logic [NCH*WORD_W-1:0]   cur_addr_o,
    output logic [NCH*WORD_W-1:0]   base_cnt_o,
    output logic [NCH*WORD_W-1:0]   cur_cnt_o
);
    access_t           acc;
    logic              hi_sel;
    logic              word_acc;
    logic              ptr_clear;
    logic              mclr;
    logic              status_rd;
    logic [NCH-1:0]    tc_set;
    logic [NCH-1:0]    tc_q;
    logic [BYTE_W-1:0] temp_q;
    logic [BYTE_W-1:0] mode_q [NCH];
    logic [WORD_W-1:0] sel_word;

    dma_bus_decode u_dec (
        .cs   (cs),
        .rd   (rd),
        .wr   (wr),
        .addr (addr),
        .acc  (acc)
    );

    assign word_acc  = (acc.rd || acc.wr) && (acc.op == OP_ADDR || acc.op == OP_CNT);
    assign mclr      = acc.wr && (acc.op == OP_MCLR);
    assign ptr_clear = mclr || (acc.wr && acc.op == OP_BPCLR);
    assign status_rd = acc.rd && (acc.op == OP_CMD);
    assign tc_set    = (eng_we && eng_tc) ? (NCH'(1) << eng_ch) : '0;

    dma_byte_ptr u_bp (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (word_acc),
        .clear  (ptr_clear),
        .hi_sel (hi_sel)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        dma_chan_regs u_regs (
            .clk       (clk),
            .rst_n     (rst_n),
            .addr_we   (acc.wr && acc.op == OP_ADDR && acc.ch == CH_W'(g)),
            .cnt_we    (acc.wr && acc.op == OP_CNT  && acc.ch == CH_W'(g)),
            .hi_sel    (hi_sel),
            .wdata     (wdata),
            .eng_we    (eng_we && eng_ch == CH_W'(g)),
            .eng_addr  (eng_addr),
            .eng_cnt   (eng_cnt),
            .base_addr (base_addr_o[g*WORD_W +: WORD_W]),
            .cur_addr  (cur_addr_o[g*WORD_W +: WORD_W]),
            .base_cnt  (base_cnt_o[g*WORD_W +: WORD_W]),
            .cur_cnt   (cur_cnt_o[g*WORD_W +: WORD_W])
        );
        assign mode_o[g*BYTE_W +: BYTE_W] = mode_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_o    <= '0;
            sw_req_o <= '0;
            mask_o   <= '1;
            tc_q     <= '0;
            temp_q   <= '0;
            for (int i = 0; i < NCH; i++) mode_q[i] <= '0;
        end else begin
            if (mclr) begin
                cmd_o    <= '0;
                sw_req_o <= '0;
                mask_o   <= '1;
                tc_q     <= '0;
                temp_q   <= '0;
            end else begin
                if (acc.wr && acc.op == OP_CMD)     cmd_o <= wdata;
                if (acc.wr && acc.op == OP_REQ)     sw_req_o[wdata[CH_W-1:0]] <= wdata[2];
                if (acc.wr && acc.op == OP_MASK1)   mask_o[wdata[CH_W-1:0]] <= wdata[2];
                if (acc.wr && acc.op == OP_MASKCLR) mask_o <= '0;
                if (acc.wr && acc.op == OP_MASKALL) mask_o <= wdata[NCH-1:0];
                tc_q <= (tc_q & ~{NCH{status_rd}}) | tc_set;
                if (temp_load) temp_q <= temp_data;
            end
            if (acc.wr && acc.op == OP_MODE) mode_q[wdata[CH_W-1:0]] <= wdata;
        end
    end

    always_comb begin
        sel_word = (acc.op == OP_CNT) ? cur_cnt_o[acc.ch*WORD_W +: WORD_W]
                                      : cur_addr_o[acc.ch*WORD_W +: WORD_W];
        rdata = '0;
        if (acc.rd) begin
            unique case (acc.op)
                OP_ADDR, OP_CNT: rdata = hi_sel ? sel_word[WORD_W-1:BYTE_W] : sel_word[BYTE_W-1:0];
                OP_CMD:          rdata = {hw_req | sw_req_o, tc_q};
                OP_MCLR:         rdata = temp_q;
                default:         rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/dma_regfile_chk.sv
module dma_regfile_chk
    import dma_regfile_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cs,
    input logic                  rd,
    input logic                  wr,
    input logic [OFS_W-1:0]      addr,
    input logic [BYTE_W-1:0]     wdata,
    input logic [BYTE_W-1:0]     rdata,
    input logic                  eng_we,
    input logic [BYTE_W-1:0]     cmd_o,
    input logic [NCH-1:0]        mask_o,
    input logic [NCH*WORD_W-1:0] base_addr_o,
    input logic [NCH*WORD_W-1:0] cur_addr_o,
    input logic [NCH*WORD_W-1:0] base_cnt_o
);
    logic wr_op;
    assign wr_op = cs && wr && !rd;

    assert_cmd_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_op && addr == 4'h8) |=> cmd_o == $past(wdata));

    assert_mclr_defaults_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_op && addr == 4'hD) |=> (mask_o == '1 && cmd_o == '0));

    assert_mask_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_op && addr == 4'hE) |=> mask_o == '0);

    assert_mask_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_op && addr == 4'hF) |=> mask_o == $past(wdata[NCH-1:0]));

    assert_base_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_we && !wr_op) |=> ($stable(base_addr_o) && $stable(base_cnt_o)));

    assert_ptr_clear_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_op && addr == 4'hC && !eng_we) |=> ($stable(cur_addr_o) && $stable(cmd_o) && $stable(mask_o)));

    assert_rdata_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && rd) |-> rdata == '0);
endmodule

bind dma_regfile dma_regfile_chk u_chk (.*);

// File: tb/dma_regfile_bench.sv
`timescale 1ns/1ps
module dma_regfile_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs = 0, rd = 0, wr = 0;
    logic [3:0]  addr = 0;
    logic [7:0]  wdata = 0;
    logic [7:0]  rdata;
    logic [3:0]  hw_req = 0;
    logic        eng_we = 0, eng_tc = 0, temp_load = 0;
    logic [1:0]  eng_ch = 0;
    logic [15:0] eng_addr = 0, eng_cnt = 0;
    logic [7:0]  temp_data = 0;
    logic [7:0]  cmd_o;
    logic [31:0] mode_o;
    logic [3:0]  mask_o, sw_req_o;
    logic [63:0] base_addr_o, cur_addr_o, base_cnt_o, cur_cnt_o;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit done = 0;
    string phase = "R1";

    always #5 clk = ~clk;

    dma_regfile u_dma_regfile (.*);

    // behavioural reference state
    int m_ba[4], m_ca[4], m_bc[4], m_cc[4], m_mode[4];
    int m_cmd, m_req, m_mask, m_tc, m_temp;
    bit m_hi;

    function automatic int put(int w, bit hi, logic [7:0] b);
        return hi ? ((w & 'h00FF) | (int'(b) << 8)) : ((w & 'hFF00) | int'(b));
    endfunction

    function automatic logic [63:0] pack16(input int a [4]);
        logic [63:0] v;
        for (int i = 0; i < 4; i++) v[i*16 +: 16] = a[i][15:0];
        return v;
    endfunction

    function automatic logic [7:0] exp_rdata();
        int v;
        if (!(cs && rd && !wr)) return 8'h00;
        if (addr < 8) begin
            v = addr[0] ? m_cc[addr[2:1]] : m_ca[addr[2:1]];
            return m_hi ? v[15:8] : v[7:0];
        end
        if (addr == 4'h8) return {hw_req | m_req[3:0], m_tc[3:0]};
        if (addr == 4'hD) return m_temp[7:0];
        return 8'h00;
    endfunction

    task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h (t=%0t)", tag, got, exp, $time);
        end
    endtask

    // model update at each rising edge
    bit r_m, w_m, blk_a, blk_c;
    int ch_m, tset, ntc;
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                m_ba[i] = 0; m_ca[i] = 0; m_bc[i] = 0; m_cc[i] = 0; m_mode[i] = 0;
            end
            m_cmd = 0; m_req = 0; m_mask = 'hF; m_tc = 0; m_temp = 0; m_hi = 0;
        end else begin
            r_m = cs && rd && !wr;
            w_m = cs && wr && !rd;
            ch_m = int'(addr[2:1]);
            blk_a = 0; blk_c = 0;
            tset = (eng_we && eng_tc) ? (1 << eng_ch) : 0;
            ntc = ((r_m && addr == 4'h8) ? 0 : m_tc) | tset;
            if (w_m && addr < 8) begin
                if (addr[0]) begin
                    m_bc[ch_m] = put(m_bc[ch_m], m_hi, wdata);
                    m_cc[ch_m] = put(m_cc[ch_m], m_hi, wdata);
                    blk_c = (ch_m == int'(eng_ch));
                end else begin
                    m_ba[ch_m] = put(m_ba[ch_m], m_hi, wdata);
                    m_ca[ch_m] = put(m_ca[ch_m], m_hi, wdata);
                    blk_a = (ch_m == int'(eng_ch));
                end
            end
            if (eng_we) begin
                if (!blk_a) m_ca[eng_ch] = int'(eng_addr);
                if (!blk_c) m_cc[eng_ch] = int'(eng_cnt);
            end
            if ((r_m || w_m) && addr < 8) m_hi = !m_hi;
            if (w_m && (addr == 4'hC || addr == 4'hD)) m_hi = 0;
            if (w_m && addr == 4'hD) begin
                m_cmd = 0; m_req = 0; m_mask = 'hF; m_tc = 0; m_temp = 0;
            end else begin
                if (w_m && addr == 4'h8) m_cmd = int'(wdata);
                if (w_m && addr == 4'h9)
                    m_req = wdata[2] ? (m_req | (1 << wdata[1:0])) : (m_req & ~(1 << wdata[1:0]));
                if (w_m && addr == 4'hA)
                    m_mask = wdata[2] ? (m_mask | (1 << wdata[1:0])) : (m_mask & ~(1 << wdata[1:0]));
                if (w_m && addr == 4'hE) m_mask = 0;
                if (w_m && addr == 4'hF) m_mask = int'(wdata[3:0]);
                m_tc = ntc;
                if (temp_load) m_temp = int'(temp_data);
            end
            if (w_m && addr == 4'hB) m_mode[wdata[1:0]] = int'(wdata);
        end
    end

    // compare every output at each falling edge
    always @(negedge clk) begin
        if (cyc >= 1 && !done) begin
            check({phase, " R3/R8/R11/R12 rdata"}, 64'(rdata), 64'(exp_rdata()));
            check({phase, " R5 cmd"}, 64'(cmd_o), 64'(m_cmd[7:0]));
            check({phase, " R6 mask"}, 64'(mask_o), 64'(m_mask[3:0]));
            check({phase, " R7 sw_req"}, 64'(sw_req_o), 64'(m_req[3:0]));
            check({phase, " R5 mode"}, 64'(mode_o),
                  64'({m_mode[3][7:0], m_mode[2][7:0], m_mode[1][7:0], m_mode[0][7:0]}));
            check({phase, " R2 base_addr"}, base_addr_o, pack16(m_ba));
            check({phase, " R10 cur_addr"}, cur_addr_o, pack16(m_ca));
            check({phase, " R2 base_cnt"}, base_cnt_o, pack16(m_bc));
            check({phase, " R10 cur_cnt"}, cur_cnt_o, pack16(m_cc));
        end
    end

    task automatic tick();
        @(posedge clk); #2;
        cs = 0; rd = 0; wr = 0; eng_we = 0; eng_tc = 0; temp_load = 0;
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
        cs = 1; wr = 1; addr = a; wdata = d;
        tick();
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [7:0] v);
        cs = 1; rd = 1; addr = a;
        @(negedge clk); v = rdata;
        tick();
    endtask

    task automatic rd_expect(string tag, input logic [3:0] a, input logic [7:0] e);
        logic [7:0] v;
        rd_reg(a, v);
        check(tag, 64'(v), 64'(e));
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        // R1 reset state
        phase = "R1";
        check("R1 mask after reset", 64'(mask_o), 64'hF);
        check("R1 cmd after reset", 64'(cmd_o), 64'h0);
        rd_expect("R1 status after reset", 4'h8, 8'h00);
        rd_expect("R1 ch0 addr low after reset", 4'h0, 8'h00);
        wr_reg(4'hC, 8'h00);
        // R2 program channel 2
        phase = "R2";
        wr_reg(4'h4, 8'h00); wr_reg(4'h4, 8'h42);
        wr_reg(4'h5, 8'hFF); wr_reg(4'h5, 8'h03);
        check("R2 ch2 base addr", 64'(base_addr_o[47:32]), 64'h4200);
        check("R2 ch2 cur addr", 64'(cur_addr_o[47:32]), 64'h4200);
        check("R2 ch2 base cnt", 64'(base_cnt_o[47:32]), 64'h03FF);
        // R3 readback
        phase = "R3";
        rd_expect("R3 ch2 addr low", 4'h4, 8'h00);
        rd_expect("R3 ch2 addr high", 4'h4, 8'h42);
        rd_expect("R3 ch2 cnt low", 4'h5, 8'hFF);
        rd_expect("R3 ch2 cnt high", 4'h5, 8'h03);
        // R4 pointer clear
        phase = "R4";
        wr_reg(4'h0, 8'h34); wr_reg(4'hC, 8'hAA); wr_reg(4'h0, 8'h12);
        check("R4 low byte rewritten after clear", 64'(cur_addr_o[15:0]), 64'h0012);
        wr_reg(4'h0, 8'h56);
        check("R4 high byte follows", 64'(cur_addr_o[15:0]), 64'h5612);
        // R5 command and mode
        phase = "R5";
        wr_reg(4'h8, 8'hA5);
        check("R5 command", 64'(cmd_o), 64'hA5);
        wr_reg(4'hB, 8'h4A); wr_reg(4'hB, 8'h87);
        check("R5 mode ch2", 64'(mode_o[23:16]), 64'h4A);
        check("R5 mode ch3", 64'(mode_o[31:24]), 64'h87);
        // R6 masks
        phase = "R6";
        wr_reg(4'hF, 8'h05); check("R6 mask all", 64'(mask_o), 64'h5);
        wr_reg(4'hA, 8'h05); check("R6 single set ch1", 64'(mask_o), 64'h7);
        wr_reg(4'hA, 8'h02); check("R6 single clear ch2", 64'(mask_o), 64'h3);
        wr_reg(4'hE, 8'hFF); check("R6 clear all", 64'(mask_o), 64'h0);
        // R7 requests
        phase = "R7";
        hw_req = 4'b0001;
        wr_reg(4'h9, 8'h07);
        check("R7 sw request ch3", 64'(sw_req_o), 64'h8);
        rd_expect("R7 status pending", 4'h8, 8'h90);
        // R8 terminal count
        phase = "R8";
        eng_we = 1; eng_ch = 2'd1; eng_tc = 1; eng_addr = 16'hBEEF; eng_cnt = 16'hFFFF;
        tick();
        check("R10 engine cur addr ch1", 64'(cur_addr_o[31:16]), 64'hBEEF);
        check("R10 engine base addr ch1 kept", 64'(base_addr_o[31:16]), 64'h0000);
        rd_expect("R8 status tc ch1", 4'h8, 8'h92);
        rd_expect("R8 status cleared by read", 4'h8, 8'h90);
        eng_we = 1; eng_ch = 2'd3; eng_tc = 1; eng_addr = 16'h0001; eng_cnt = 16'h0002;
        rd_expect("R8 read during set returns old", 4'h8, 8'h90);
        rd_expect("R8 same-cycle set survives", 4'h8, 8'h98);
        // R10 conflict on channel 0
        phase = "R10";
        cs = 1; wr = 1; addr = 4'h0; wdata = 8'h77;
        eng_we = 1; eng_ch = 2'd0; eng_tc = 0; eng_addr = 16'h1111; eng_cnt = 16'h2222;
        tick();
        check("R10 cpu write wins addr", 64'(cur_addr_o[15:0]), 64'h5677);
        check("R10 engine count applied", 64'(cur_cnt_o[15:0]), 64'h2222);
        check("R10 base count kept", 64'(base_cnt_o[15:0]), 64'h0000);
        // R11 temporary byte
        phase = "R11";
        temp_load = 1; temp_data = 8'h3C; tick();
        rd_expect("R11 temp readback", 4'hD, 8'h3C);
        // R9 master clear (pointer is in high state here)
        phase = "R9";
        wr_reg(4'hD, 8'h00);
        check("R9 mask set", 64'(mask_o), 64'hF);
        check("R9 cmd cleared", 64'(cmd_o), 64'h00);
        check("R9 req cleared", 64'(sw_req_o), 64'h0);
        check("R9 address kept", 64'(cur_addr_o[47:32]), 64'h4200);
        check("R9 mode kept", 64'(mode_o[23:16]), 64'h4A);
        rd_expect("R9 temp cleared", 4'hD, 8'h00);
        rd_expect("R9 status cleared", 4'h8, 8'h10);
        wr_reg(4'h6, 8'h11);
        check("R9 pointer back to low", 64'(base_addr_o[63:48]), 64'h0011);
        // R12 write-only offsets read zero
        phase = "R12";
        rd_expect("R12 read offset 9", 4'h9, 8'h00);
        rd_expect("R12 read offset B", 4'hB, 8'h00);
        rd_expect("R12 read offset F", 4'hF, 8'h00);
        // mixed random traffic, model compared every cycle
        phase = "RND";
        for (int i = 0; i < 600; i++) begin
            int k;
            k = $urandom_range(0, 9);
            if (k < 4) begin cs = 1; wr = 1; addr = 4'($urandom_range(0, 15)); wdata = 8'($urandom); end
            else if (k < 7) begin cs = 1; rd = 1; addr = 4'($urandom_range(0, 15)); end
            if ($urandom_range(0, 3) == 0) begin
                eng_we = 1; eng_ch = 2'($urandom); eng_tc = 1'($urandom);
                eng_addr = 16'($urandom); eng_cnt = 16'($urandom);
            end
            if ($urandom_range(0, 7) == 0) begin temp_load = 1; temp_data = 8'($urandom); end
            if ($urandom_range(0, 15) == 0) hw_req = 4'($urandom);
            tick();
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule